// File: doc/BRIEF.md
# Phase-Switching Programmable Frequency Divider

This block divides a fast input clock by a modulus picked from a small, contiguous range. It first makes four square waves at one quarter of the input rate. Each wave's rising edge comes one input cycle after the previous wave's rising edge. One wave at a time passes through a selector into a fixed divide-by-N chain. If the selector never moved, the block would divide by 4N.

To lengthen an output period, a pulse generator inside the chain issues K swallow requests in each output cycle. Each request steps the selector to the wave that lags by a quarter turn. The step is taken only while both the old and the new wave are high, so the muxed clock never shows an extra edge. Each step delays the next chain edge by exactly one input cycle, and the period becomes 4N + K.

K comes from a 3-bit code. Code values that would leave the legal range of K are clamped. The block picks up a new code only as an output cycle begins. The model is cycle-based: every register runs on the input clock, and the four waves are decoded from a two-stage Johnson counter. The ports are control and clock pins only, so no valid/ready stream interface applies.

Top module: `phase_swallow_divider`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) holds `div_out` low, selects wave 0, clears the chain count and loads K from `mod_code`. On the first rising edge with `rst` low, `div_out` goes high.
- R2: Exactly one of the four waves is selected in every cycle.
- R3: For `mod_code` values 0 to 4, successive rising edges of `div_out` are 4*N_DIV + (mod_code + 4) input cycles apart. The default N_DIV is 54, which gives 220 to 224.
- R4: The selector only advances by one position, in the order wave 0, 1, 2, 3, 0. Wave i rises one input cycle after wave i-1. A step happens only in a cycle where both the old and the new wave are high. Each step adds exactly one input cycle to the current output period.
- R5: The codes 5, 6 and 7 are clamped to K = 8, which gives a period of 4*N_DIV + 8 (224 by default).
- R6: `mod_code` is sampled only when an output cycle begins. If the code changes after a rising edge of `div_out`, the period already under way keeps the old ratio and the next period uses the new ratio. No period of any other length appears.
- R7: In each output cycle, `div_out` stays high for 4*(N_DIV/2) + K input cycles. This is 108 + K by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_code | input | 3 | Modulus code; K = code + 4, clamped to 8 |
| div_out | output | 1 | Divided clock, period 4*N_DIV + K input cycles |

## Verification
A selector that steps at the wrong instant or in the wrong direction shows up at the ports within one output period. It adds or removes input cycles from the period, or from the high time of `div_out`. A wrong K, or a wrong clamp, changes the very next period by a whole number of cycles. A code that is picked up at the wrong moment makes the period that straddles a code change take the new ratio one period too early, or too late. So every transition between each pair of codes is measured both in period and in high time.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Wave index, in the order of their rising edges
  typedef enum logic [1:0] {
    WAVE_0 = 2'd0,
    WAVE_1 = 2'd1,
    WAVE_2 = 2'd2,
    WAVE_3 = 2'd3
  } wave_sel_e;

  localparam int NUM_WAVES = 4;

  // Swallow count for a programming code, clamped into [kmin, kmax]
  function automatic int code_to_k(input int code, input int kmin, input int kmax);
    int v;
    v = kmin + code;
    if (v > kmax) v = kmax;
    if (v < kmin) v = kmin;
    return v;
  endfunction

endpackage

// File: rtl/psd_phase_gen.sv
module psd_phase_gen
  import psd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  output logic [1:0]           phase_idx,
  output logic [NUM_WAVES-1:0] waves
);

  // Two cascaded toggle stages arranged as a 2-bit Johnson ring
  logic [1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst) ring_q <= 2'b00;
    else     ring_q <= {ring_q[0], ~ring_q[1]};
  end

  // Ring 00,01,11,10 maps to quarter index 0,1,2,3
  assign phase_idx = {ring_q[1], ring_q[1] ^ ring_q[0]};

  // Wave g is high during quarters g and g+1, so it rises one cycle after wave g-1
  for (genvar g = 0; g < NUM_WAVES; g++) begin : g_wave
    localparam logic [1:0] Q_RISE = 2'(g);
    localparam logic [1:0] Q_HOLD = 2'((g + 1) % NUM_WAVES);
    assign waves[g] = (phase_idx == Q_RISE) | (phase_idx == Q_HOLD);
  end

endmodule

// File: rtl/psd_retimer.sv
module psd_retimer
  import psd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WAVES-1:0] waves,
  input  logic                 swallow_req,
  output logic [1:0]           sel_idx,
  output logic [NUM_WAVES-1:0] sel_oh,
  output logic                 tick
);

  logic [1:0] sel_q;
  logic [1:0] sel_next;
  logic       pending_q;
  logic       mux_out;
  logic       mux_prev_q;
  logic       window;
  logic       do_step;

  assign sel_next = sel_q + 2'd1;
  assign mux_out  = waves[sel_q];
  // Safe window: the current wave and the one lagging it are both high
  assign window   = waves[sel_q] & waves[sel_next];
  assign do_step  = pending_q & window;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= WAVE_0;
      pending_q  <= 1'b0;
      mux_prev_q <= 1'b0;
    end else begin
      mux_prev_q <= mux_out;
      if (do_step) begin
        sel_q     <= sel_next;
        pending_q <= 1'b0;
      end else if (swallow_req) begin
        pending_q <= 1'b1;
      end
    end
  end

  // The chain is advanced by the rising edge of the muxed wave
  assign tick    = mux_out & ~mux_prev_q;
  assign sel_idx = sel_q;

  for (genvar g = 0; g < NUM_WAVES; g++) begin : g_dec
    assign sel_oh[g] = (sel_q == 2'(g));
  end

endmodule

// File: rtl/psd_chain.sv
module psd_chain
  import psd_pkg::*;
#(
  parameter int N_DIV  = 54,
  parameter int CODE_W = 3,
  parameter int K_MIN  = 4,
  parameter int K_MAX  = 8,
  localparam int CW    = $clog2(N_DIV),
  localparam int KW    = $clog2(K_MAX + 1),
  localparam int HALF  = N_DIV / 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] mod_code,
  output logic [CW-1:0]     count_q,
  output logic [KW-1:0]     k_q,
  output logic              swallow_req,
  output logic              div_out
);

  logic [KW-1:0] k_new;
  logic          last_tick;
  logic          out_q;

  assign k_new     = KW'(code_to_k(int'(mod_code), K_MIN, K_MAX));
  assign last_tick = (count_q == CW'(N_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      k_q     <= k_new;
      out_q   <= 1'b0;
    end else if (tick) begin
      if (last_tick) begin
        count_q <= '0;
        k_q     <= k_new;   // the new code applies from the next cycle start
      end else begin
        count_q <= count_q + 1'b1;
      end
      out_q <= (int'(count_q) < HALF);
    end
  end

  // The first K chain edges of each output cycle each request one swallow
  assign swallow_req = tick & (int'(count_q) < int'(k_q));
  assign div_out     = out_q;

endmodule

// File: rtl/phase_swallow_divider.sv
module phase_swallow_divider
  import psd_pkg::*;
#(
  parameter int N_DIV  = 54,
  parameter int CODE_W = 3,
  parameter int K_MIN  = 4,
  parameter int K_MAX  = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] mod_code,
  output logic              div_out
);

  localparam int CW = $clog2(N_DIV);
  localparam int KW = $clog2(K_MAX + 1);

  logic [1:0]           phase_idx;
  logic [NUM_WAVES-1:0] waves;
  logic [1:0]           sel_idx;
  logic [NUM_WAVES-1:0] sel_oh;
  logic                 tick;
  logic                 swallow_req;
  logic [CW-1:0]        count_q;
  logic [KW-1:0]        k_q;

  psd_phase_gen u_phase (
    .clk       (clk),
    .rst       (rst),
    .phase_idx (phase_idx),
    .waves     (waves)
  );

  psd_retimer u_retime (
    .clk         (clk),
    .rst         (rst),
    .waves       (waves),
    .swallow_req (swallow_req),
    .sel_idx     (sel_idx),
    .sel_oh      (sel_oh),
    .tick        (tick)
  );

  psd_chain #(
    .N_DIV  (N_DIV),
    .CODE_W (CODE_W),
    .K_MIN  (K_MIN),
    .K_MAX  (K_MAX)
  ) u_chain (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .mod_code    (mod_code),
    .count_q     (count_q),
    .k_q         (k_q),
    .swallow_req (swallow_req),
    .div_out     (div_out)
  );

endmodule

// File: rtl/psd_chk.sv
module psd_chk #(
  parameter int N_DIV = 54,
  parameter int K_MIN = 4,
  parameter int K_MAX = 8,
  parameter int CW    = 6,
  parameter int KW    = 4
)(
  input logic          clk,
  input logic          rst,
  input logic          div_out,
  input logic [1:0]    sel_idx,
  input logic [3:0]    sel_oh,
  input logic [3:0]    waves,
  input logic [CW-1:0] count_q,
  input logic [KW-1:0] k_q
);

  logic [1:0]  sel_nx;
  logic        win_d;
  logic        rst_d;
  logic        seen;
  logic [15:0] cyc;
  logic [KW-1:0] k_prev;

  assign sel_nx = sel_idx + 2'd1;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    win_d <= waves[sel_idx] & waves[sel_nx];
    if (rst) begin
      seen   <= 1'b0;
      cyc    <= '0;
      k_prev <= '0;
    end else if (div_out && !seen) begin
      seen   <= 1'b1;
      cyc    <= 16'd1;
      k_prev <= k_q;
    end else if ($rose(div_out)) begin
      cyc    <= 16'd1;
      k_prev <= k_q;
    end else begin
      cyc <= cyc + 16'd1;
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_d && !rst)
      reset_state_chk: assert (div_out == 1'b0 && sel_idx == 2'd0 && count_q == '0);
  end

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_oh) == 1);

  // R4
  lag_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_idx) |-> (sel_idx == 2'($past(sel_idx) + 2'd1)));

  // R4
  step_window_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_idx) |-> win_d);

  // R5
  k_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(k_q) >= K_MIN) && (int'(k_q) <= K_MAX));

  // R6
  k_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(k_q) |-> (count_q == '0));

  // R3
  period_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_out) && seen) |-> (int'(cyc) == 4 * N_DIV + int'(k_prev)));

endmodule

bind phase_swallow_divider psd_chk #(
  .N_DIV (N_DIV),
  .K_MIN (K_MIN),
  .K_MAX (K_MAX),
  .CW    (CW),
  .KW    (KW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .div_out (div_out),
  .sel_idx (sel_idx),
  .sel_oh  (sel_oh),
  .waves   (waves),
  .count_q (count_q),
  .k_q     (k_q)
);

// File: tb/tb_phase_swallow_divider.sv
module tb_phase_swallow_divider;

  localparam int N_DIV = 54;
  localparam int HALF  = N_DIV / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mod_code = 3'd0;
  logic       div_out;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  phase_swallow_divider #(.N_DIV(N_DIV)) dut (
    .clk      (clk),
    .rst      (rst),
    .mod_code (mod_code),
    .div_out  (div_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_k(input int c);
    return (c > 4) ? 8 : c + 4;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_change(input logic lvl, output int t);
    logic last;
    last = div_out;
    forever begin
      @(negedge clk);
      if (div_out == lvl && last != lvl) break;
      last = div_out;
    end
    t = cyc;
  endtask

  int t_rise;
  int cur;

  // One output cycle: present a new code just after a rise, then measure
  // the high time and the period, which both belong to the old code (R6)
  task automatic step(input int newc);
    int tf;
    int tr;
    string tag;
    mod_code = 3'(newc);
    wait_change(1'b0, tf);
    check($sformatf("R7 high time code %0d", cur), tf - t_rise, 4 * HALF + exp_k(cur));
    wait_change(1'b1, tr);
    tag = (cur > 4) ? "R5" : "R3";
    if (newc != cur) tag = {tag, " R6"};
    check($sformatf("%s R2 R4 period code %0d then %0d", tag, cur, newc),
          tr - t_rise, 4 * N_DIV + exp_k(cur));
    t_rise = tr;
    cur    = newc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1;
    mod_code = 3'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 div_out low in reset", int'(div_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 div_out high one edge after reset", int'(div_out), 1);
    t_rise = cyc;
    cur = 0;
    // every ordered pair of codes, including a code followed by itself
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        step(a);
        step(b);
      end
    end
    step(cur);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule